// File: doc/BRIEF.md
# Master clock prescaler and selector

This block derives a processor clock and an identical master clock from one of four incoming clocks: a slow clock, the main clock and two PLL outputs. A glitch-free multiplexer picks the source. A prescaler divides it by 1, 2, 3, 4, 8, 16, 32 or 64. Software programs the block through a small write port that carries a prescale code, a source code and an interrupt enable. A ready status, and an interrupt gated by the enable, tell software when the last change has fully taken effect.

Changing the ratio and changing the source are separate steps. Software first writes a new ratio and waits for ready. Only then does it write a new source. A write that changes both codes at once is refused, and so is any write made while ready is low. A refused write raises an error flag and leaves the current setting in force.

Top module: `mck_gen`

## Requirements
- R1: After reset the source code is 1 (main clock), the prescale code is 0 (divide by 1), ready is 1, the error flag is 0 and the interrupt is 0.
- R2: Prescale codes 0 to 7 select division by 1, 2, 3, 4, 8, 16, 32 and 64. The output period is the source period times that ratio. cpu_clk and mst_clk are always equal.
- R3: Even ratios give a 50% duty cycle. Ratio 3 gives one source period high and two low. Ratio 1 passes the source through unchanged.
- R4: An accepted write that changes the prescale code drives ready low from the next bus cycle. Ready returns high only once the output runs at the new ratio.
- R5: Source codes are 0 slow clock, 1 main clock, 2 PLL A and 3 PLL B. An accepted write that changes the source code drives ready low from the next bus cycle. Ready returns high only once the output runs from the new source.
- R6: A write that changes both the prescale code and the source code is refused. It sets wr_err, keeps both codes, and leaves ready high.
- R7: A write made while ready is low is refused and sets wr_err.
- R8: An accepted write clears wr_err. It also loads the interrupt enable, even when neither code changes.
- R9: irq is high exactly when ready is high and the interrupt enable is set.
- R10: At most one source is gated through at any time. No high or low phase of the output is shorter than half the period of the fastest input clock.
- R11: A new ratio takes effect only at the end of the current output period, and each new period starts with its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Clock of the write port and status |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_pres | input | 3 | Prescale code written |
| wr_src | input | 2 | Source code written |
| wr_irq_en | input | 1 | Interrupt enable written |
| clk_slow | input | 1 | Source 0, slow clock |
| clk_main | input | 1 | Source 1, main clock |
| clk_plla | input | 1 | Source 2, PLL A output |
| clk_pllb | input | 1 | Source 3, PLL B output |
| cpu_clk | output | 1 | Processor clock |
| mst_clk | output | 1 | Master clock, same as cpu_clk |
| ready | output | 1 | Last change has taken effect |
| irq | output | 1 | Ready interrupt |
| wr_err | output | 1 | Last write was refused |
| cfg_pres | output | 3 | Prescale code in force |
| cfg_src | output | 2 | Source code in force |

## Verification
The hardest case to reach from the ports is a second write that lands inside the busy window of the first. The window lasts only a few bus cycles when a fast source is selected. The bench therefore issues a ratio change on PLL A and a source change two bus cycles later, which is well inside the time the request and acknowledge need to cross both clock domains. Short output pulses at the moment of a ratio or source switch are also hard to see directly. A monitor records the narrowest high and low phases of the output over the whole run, across every transition between ratio 1, ratio 3, even ratios and all four sources.

// File: rtl/mck_pkg.sv
`timescale 1ns/1ps
package mck_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int PRES_W  = 3;
  localparam int CNT_W   = 6;
  localparam int SRC_RST = 1;

  // terminal count (ratio - 1) for a prescale code
  function automatic logic [CNT_W-1:0] ratio_m1(input logic [PRES_W-1:0] c);
    case (c)
      3'd0:    ratio_m1 = CNT_W'(0);
      3'd1:    ratio_m1 = CNT_W'(1);
      3'd2:    ratio_m1 = CNT_W'(2);
      3'd3:    ratio_m1 = CNT_W'(3);
      3'd4:    ratio_m1 = CNT_W'(7);
      3'd5:    ratio_m1 = CNT_W'(15);
      3'd6:    ratio_m1 = CNT_W'(31);
      default: ratio_m1 = CNT_W'(63);
    endcase
  endfunction

  // number of source cycles the divided clock stays high (0 = pass-through)
  function automatic logic [CNT_W-1:0] high_len(input logic [PRES_W-1:0] c);
    case (c)
      3'd0:    high_len = CNT_W'(0);
      3'd1:    high_len = CNT_W'(1);
      3'd2:    high_len = CNT_W'(1);
      3'd3:    high_len = CNT_W'(2);
      3'd4:    high_len = CNT_W'(4);
      3'd5:    high_len = CNT_W'(8);
      3'd6:    high_len = CNT_W'(16);
      default: high_len = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/mck_sync2.sv
`timescale 1ns/1ps
module mck_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RV;
      q  <= RV;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mck_srcmux.sv
`timescale 1ns/1ps
module mck_srcmux
  import mck_pkg::*;
(
  input  logic              rst_n,
  input  logic [NSRC-1:0]   clk_in,
  input  logic [SRC_W-1:0]  src_sel,
  output logic [NSRC-1:0]   en_q,
  output logic              clk_out
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic RV_I = (i == SRC_RST);
    logic others_on, want, want_s, en_l;
    assign others_on = |(en_q & ~(NSRC'(1) << i));
    assign want      = (src_sel == SRC_W'(i)) && !others_on;

    mck_sync2 #(.W(1), .RV(RV_I)) u_sync (
      .clk(clk_in[i]), .rst_n(rst_n), .d(want), .q(want_s)
    );

    // enable changes only on this clock's low phase
    always_ff @(negedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) en_l <= RV_I;
      else        en_l <= want_s;
    end

    assign en_q[i]  = en_l;
    assign gated[i] = clk_in[i] & en_l;
  end

  assign clk_out = |gated;
endmodule

// File: rtl/mck_prescaler.sv
`timescale 1ns/1ps
module mck_prescaler
  import mck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRES_W-1:0] code_in,
  input  logic              req_t,
  output logic              ack_t,
  output logic              clk_out
);
  logic              req_s;
  logic [PRES_W-1:0] act;
  logic [CNT_W-1:0]  cnt;
  logic              div_q, pass_g;

  mck_sync2 #(.W(1), .RV(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n), .d(req_t), .q(req_s)
  );

  // named internal events
  logic              at_end, take;
  logic [PRES_W-1:0] nxt_code;
  logic [CNT_W-1:0]  nxt_cnt;
  assign at_end   = (cnt == ratio_m1(act));
  assign take     = at_end && (req_s != ack_t);
  assign nxt_code = take ? code_in : act;
  assign nxt_cnt  = at_end ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      cnt   <= '0;
      div_q <= 1'b0;
      ack_t <= 1'b0;
    end else begin
      act   <= nxt_code;
      cnt   <= nxt_cnt;
      div_q <= (nxt_cnt < high_len(nxt_code));
      if (take) ack_t <= req_s;
    end
  end

  // pass-through gate for ratio 1, switched on the low phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_g <= 1'b1;
    else        pass_g <= (act == '0);
  end

  assign clk_out = div_q | (pass_g & clk);

  // R11: ratio held steady within a period
  p_ratio_at_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(act));
  // R11: a divided period starts high
  p_period_starts_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && nxt_code != '0) |=> div_q);
endmodule

// File: rtl/mck_ctrl.sv
`timescale 1ns/1ps
module mck_ctrl
  import mck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PRES_W-1:0] wr_pres,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic              wr_ie,
  input  logic [NSRC-1:0]   en_async,
  input  logic              ack_async,
  output logic [PRES_W-1:0] pres_q,
  output logic [SRC_W-1:0]  src_q,
  output logic              req_t,
  output logic              ie_q,
  output logic              err_q,
  output logic              ready
);
  localparam logic [NSRC-1:0] EN_RST = NSRC'(1) << SRC_RST;

  logic [NSRC-1:0] en_s;
  logic            ack_s;

  mck_sync2 #(.W(NSRC), .RV(EN_RST)) u_en (
    .clk(clk), .rst_n(rst_n), .d(en_async), .q(en_s)
  );
  mck_sync2 #(.W(1), .RV(1'b0)) u_ack (
    .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
  );

  logic pres_ok, src_ok, pres_chg, src_chg, accept, reject;
  assign pres_ok  = (ack_s == req_t);
  assign src_ok   = (en_s == (NSRC'(1) << src_q));
  assign ready    = pres_ok && src_ok;
  assign pres_chg = (wr_pres != pres_q);
  assign src_chg  = (wr_src != src_q);
  assign accept   = wr_en && ready && !(pres_chg && src_chg);
  assign reject   = wr_en && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      src_q  <= SRC_W'(SRC_RST);
      req_t  <= 1'b0;
      ie_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      pres_q <= wr_pres;
      src_q  <= wr_src;
      ie_q   <= wr_ie;
      err_q  <= 1'b0;
      if (pres_chg) req_t <= ~req_t;
    end else if (reject) begin
      err_q  <= 1'b1;
    end
  end

  p_busy_after_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pres_chg) |=> !ready);
  p_busy_after_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && src_chg) |=> !ready);
  p_dual_change_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && pres_chg && src_chg) |=> (err_q && $stable(pres_q) && $stable(src_q)));
  p_busy_write_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> (err_q && $stable(pres_q) && $stable(src_q)));
endmodule

// File: rtl/mck_gen.sv
`timescale 1ns/1ps
module mck_gen
  import mck_pkg::*;
(
  input  logic        clk_bus,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_pres,
  input  logic [1:0]  wr_src,
  input  logic        wr_irq_en,
  input  logic        clk_slow,
  input  logic        clk_main,
  input  logic        clk_plla,
  input  logic        clk_pllb,
  output logic        cpu_clk,
  output logic        mst_clk,
  output logic        ready,
  output logic        irq,
  output logic        wr_err,
  output logic [2:0]  cfg_pres,
  output logic [1:0]  cfg_src
);
  logic [NSRC-1:0]   clk_v, en_q;
  logic [PRES_W-1:0] pres_q;
  logic [SRC_W-1:0]  src_q;
  logic              req_t, ack_t, ie_q, mux_clk, pre_clk;

  assign clk_v = {clk_pllb, clk_plla, clk_main, clk_slow};

  mck_ctrl u_ctrl (
    .clk(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .wr_pres(wr_pres),
    .wr_src(wr_src), .wr_ie(wr_irq_en), .en_async(en_q), .ack_async(ack_t),
    .pres_q(pres_q), .src_q(src_q), .req_t(req_t), .ie_q(ie_q),
    .err_q(wr_err), .ready(ready)
  );

  mck_srcmux u_mux (
    .rst_n(rst_n), .clk_in(clk_v), .src_sel(src_q), .en_q(en_q),
    .clk_out(mux_clk)
  );

  mck_prescaler u_pres (
    .clk(mux_clk), .rst_n(rst_n), .code_in(pres_q), .req_t(req_t),
    .ack_t(ack_t), .clk_out(pre_clk)
  );

  assign cpu_clk  = pre_clk;
  assign mst_clk  = pre_clk;
  assign irq      = ready & ie_q;
  assign cfg_pres = pres_q;
  assign cfg_src  = src_q;

  // R10: never two sources gated at once
  p_single_gate_r10: assert property (@(posedge clk_bus) disable iff (!rst_n)
    $onehot0(en_q));
endmodule

// File: tb/sim_mck_gen.sv
`timescale 1ns/1ps
module sim_mck_gen;
  logic clk_bus = 0, clk_slow = 0, clk_main = 0, clk_plla = 0, clk_pllb = 0;
  logic rst_n = 0, wr_en = 0, wr_irq_en = 0;
  logic [2:0] wr_pres = 0;
  logic [1:0] wr_src = 0;
  logic cpu_clk, mst_clk, ready, irq, wr_err;
  logic [2:0] cfg_pres;
  logic [1:0] cfg_src;

  always #2.5 clk_bus  = ~clk_bus;   // 200 MHz
  always #15  clk_slow = ~clk_slow;  // 30 ns
  always #4   clk_main = ~clk_main;  // 8 ns
  always #1.5 clk_plla = ~clk_plla;  // 3 ns
  always #3   clk_pllb = ~clk_pllb;  // 6 ns

  mck_gen u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", rq, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string rq, input string what, input real act, input real exp);
    chk(near(act, exp), rq, what, act, exp);
  endtask

  // glitch monitor over the whole run (R10, R11)
  real t_r = -1, t_f = -1, min_hi = 1.0e9, min_lo = 1.0e9;
  int  mism = 0;
  always @(posedge mst_clk) begin
    if (rst_n && t_f >= 0 && ($realtime - t_f) < min_lo) min_lo = $realtime - t_f;
    t_r = $realtime;
  end
  always @(negedge mst_clk) begin
    if (rst_n && t_r >= 0 && ($realtime - t_r) < min_hi) min_hi = $realtime - t_r;
    t_f = $realtime;
  end
  always @(negedge clk_bus) if (cpu_clk !== mst_clk) mism++;

  task automatic do_write(input logic [2:0] p, input logic [1:0] s, input logic ie);
    @(negedge clk_bus);
    wr_en = 1; wr_pres = p; wr_src = s; wr_irq_en = ie;
    @(negedge clk_bus);
    wr_en = 0;
  endtask

  task automatic wait_ready(input string rq);
    int n = 0;
    while (!ready && n < 20000) begin
      @(negedge clk_bus);
      n++;
    end
    chk(ready === 1'b1, rq, "ready returns", real'(ready), 1.0);
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, th;
    repeat (3) @(posedge mst_clk);
    t0 = $realtime;
    @(negedge mst_clk); th = $realtime;
    @(posedge mst_clk); t1 = $realtime;
    per = t1 - t0;
    hi  = th - t0;
  endtask

  task automatic t_reset;
    real per, hi;
    chk_eq("R1", "cfg_src", real'(cfg_src), 1.0);
    chk_eq("R1", "cfg_pres", real'(cfg_pres), 0.0);
    chk_eq("R1", "ready", real'(ready), 1.0);
    chk_eq("R1", "wr_err", real'(wr_err), 0.0);
    chk_eq("R1", "irq", real'(irq), 0.0);
    measure(per, hi);
    chk_eq("R3", "div1 period on main", per, 8.0);
    chk_eq("R3", "div1 high on main", hi, 4.0);
  endtask

  task automatic t_ratio(input logic [2:0] p, input logic [1:0] s, input logic ie,
                         input real exp_per, input real exp_hi, input string rq);
    real per, hi;
    do_write(p, s, ie);
    chk_eq(rq, "ready low after change", real'(ready), 0.0);
    wait_ready(rq);
    chk_eq("R8", "err cleared by accepted write", real'(wr_err), 0.0);
    measure(per, hi);
    chk_eq("R2", "period", per, exp_per);
    chk_eq("R3", "high time", hi, exp_hi);
  endtask

  task automatic t_dual_reject;
    real per, hi;
    do_write(3'd3, 2'd2, 1'b0);
    chk_eq("R6", "wr_err", real'(wr_err), 1.0);
    chk_eq("R6", "ready kept high", real'(ready), 1.0);
    chk_eq("R6", "cfg_pres kept", real'(cfg_pres), 2.0);
    chk_eq("R6", "cfg_src kept", real'(cfg_src), 1.0);
    measure(per, hi);
    chk_eq("R6", "period unchanged", per, 24.0);
  endtask

  task automatic t_busy_write;
    real per, hi;
    do_write(3'd3, 2'd2, 1'b0);  // ratio 4 on PLL A
    do_write(3'd3, 2'd3, 1'b0);  // issued while busy
    chk_eq("R7", "wr_err after busy write", real'(wr_err), 1.0);
    wait_ready("R4");
    chk_eq("R7", "cfg_src kept", real'(cfg_src), 2.0);
    measure(per, hi);
    chk_eq("R4", "period at new ratio", per, 12.0);
    chk_eq("R3", "high time ratio 4", hi, 6.0);
  endtask

  task automatic t_irq;
    do_write(3'd3, 2'd2, 1'b1);  // no field change, enable only
    chk_eq("R8", "err cleared", real'(wr_err), 0.0);
    chk_eq("R9", "irq with ready", real'(irq), 1.0);
    do_write(3'd7, 2'd2, 1'b1);
    chk_eq("R9", "irq low while busy", real'(irq), 0.0);
    wait_ready("R4");
    chk_eq("R9", "irq back high", real'(irq), 1.0);
  endtask

  initial begin
    repeat (10) @(negedge clk_bus);
    rst_n = 1;
    repeat (10) @(negedge clk_bus);
    t_reset();
    t_ratio(3'd1, 2'd1, 1'b0, 16.0, 8.0, "R4");     // ratio 2 on main
    t_ratio(3'd2, 2'd1, 1'b0, 24.0, 8.0, "R4");     // ratio 3 on main
    t_dual_reject();
    t_ratio(3'd2, 2'd2, 1'b0, 9.0, 3.0, "R5");      // PLL A, ratio 3
    t_busy_write();
    t_irq();
    begin
      real per, hi;
      measure(per, hi);
      chk_eq("R2", "ratio 64 on PLL A", per, 192.0);
      chk_eq("R3", "ratio 64 high", hi, 96.0);
    end
    t_ratio(3'd7, 2'd3, 1'b1, 384.0, 192.0, "R5");  // PLL B
    t_ratio(3'd7, 2'd0, 1'b1, 1920.0, 960.0, "R5"); // slow clock
    t_ratio(3'd0, 2'd0, 1'b1, 30.0, 15.0, "R4");    // ratio 1 on slow
    t_ratio(3'd0, 2'd1, 1'b0, 8.0, 4.0, "R5");      // back to main
    chk_eq("R9", "irq off with enable clear", real'(irq), 0.0);
    chk(min_hi > 1.49, "R10", "narrowest high phase (R11)", min_hi, 1.5);
    chk(min_lo > 1.49, "R10", "narrowest low phase (R11)", min_lo, 1.5);
    chk_eq("R2", "cpu_clk/mst_clk mismatches", real'(mism), 0.0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_bus);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule